// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a set of shared interrupt inputs and steers each one onto the interrupt lines of one or more processor cores. Every shared input owns three settings: a destination mask with one bit per core, a mode word that selects how the input is delivered, and a mask bit. Software changes these settings through a single-cycle command strobe. Each command carries an operation code, the index of a shared input and a 32-bit data word. A separate enable command opens all routing at once. Until that command arrives, no core line is raised.

Shared input i always lands on line i of the cores it selects. The flat output vector therefore holds one group of lines per core. Three delivery styles are available. A fixed-destination input goes to one core. A broadcast input goes to every selected core. A rotating input goes to one selected core, and each new assertion moves on to the next selected core. The command port is a plain strobe with no back-pressure: a command presented with `cmd_valid` high on a rising clock edge always takes effect at that edge. A read-only output reports how many shared inputs were built.

Top module: `shared_irq_router`

## Requirements
- R1: On a clock edge with `cmd_valid` high, `cmd_op` selects the operation: 1 = global enable (data ignored), 2 = write destination mask (`cmd_data[NUM_CORES-1:0]`, bit c selects core c), 3 = write mode word, 4 = write mask bit (`cmd_data[0]`). Any other code changes nothing. Only the input numbered `cmd_idx` is written.
- R2: Shared input i drives output bit `c*NUM_IRQ + i` of `core_irq` for each core c that it is delivered to.
- R3: Mode word bits [1:0] select the distribution mode. In mode 0 (fixed destination), the input goes only to the lowest-numbered core set in its destination mask. Mode 3 behaves like mode 0.
- R4: In mode 2 (broadcast), the input goes to every core set in its destination mask.
- R5: In mode 1 (rotating), each rising edge of the unmasked, enabled request picks the next set bit of the destination mask after the core last served, wrapping from the top core to core 0. After reset the search starts from core 0.
- R6: In mode 1 with level trigger, the chosen core keeps the line for as long as the request stays high, even if the destination mask changes.
- R7: After reset every input is masked. Mask data 1 masks the input and data 0 unmasks it. A masked input drives no line.
- R8: No line is driven before the first global enable command.
- R9: A destination mask of zero delivers nothing in every mode.
- R10: Mode word bit 4 selects the trigger: 1 = level (the line follows the input), 0 = edge (a one-cycle pulse on each rising edge). All other mode word bits are ignored. The reset mode is level, fixed destination, and the reset destination mask is zero.
- R11: `cfg_num_irq` reads back the constant NUM_IRQ.
- R12: The outputs are registered. An input change sampled at a clock edge shows on `core_irq` right after that edge. A setting written at one edge affects `core_irq` after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation code |
| cmd_idx | input | IDX_W | Index of the shared input being written |
| cmd_data | input | 32 | Command data word |
| irq_in | input | NUM_IRQ | Shared interrupt inputs |
| core_irq | output | NUM_CORES*NUM_IRQ | Per-core interrupt lines, grouped by core |
| cfg_num_irq | output | 16 | Number of shared inputs built |

## Verification
The bench walks the rotating mode through a sparse destination mask, so that it must skip a clear bit and wrap around. A picker that does not skip clear bits or does not wrap would raise an unselected core or get stuck on one core. It holds a rotating request high while it rewrites the destination mask. A design that re-picks every cycle would move the line between cores in the middle of an interrupt. It also raises a request before the global enable, with a zero destination, while masked, and with mode 3 and junk bits set in the mode word. A design that leaks through the enable or the mask, treats mode 3 as a new mode, or decodes the ignored bits would light a wrong line. Finally it samples either side of a single edge to catch an extra or a missing register stage.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ENABLE = 3'd1,
    OP_DEST   = 3'd2,
    OP_MODE   = 3'd3,
    OP_MASK   = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    DIST_FIXED = 2'd0,
    DIST_ROT   = 2'd1,
    DIST_ALL   = 2'd2,
    DIST_ALT   = 2'd3
  } dist_mode_e;

  localparam int DATA_W   = 32;
  localparam int TRIG_BIT = 4;
endpackage

// File: rtl/rot_pick.sv
module rot_pick #(
  parameter int NUM_CORES = 4,
  localparam int PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] cand,
  input  logic [PTR_W-1:0]     last,
  output logic [NUM_CORES-1:0] pick,
  output logic [PTR_W-1:0]     pick_idx,
  output logic [NUM_CORES-1:0] low_pick
);
  always_comb begin
    pick     = '0;
    pick_idx = last;
    for (int k = NUM_CORES; k >= 1; k--) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= NUM_CORES) idx = idx - NUM_CORES;
      if (cand[idx]) begin
        pick     = '0;
        pick[idx] = 1'b1;
        pick_idx = PTR_W'(idx);
      end
    end
  end

  always_comb begin
    low_pick = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (cand[c]) begin
        low_pick    = '0;
        low_pick[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_lane.sv
module irq_lane
  import shared_irq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 irq_in,
  input  logic                 wr_dest,
  input  logic                 wr_mode,
  input  logic                 wr_mask,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_CORES-1:0] tgt_o
);
  localparam int PTR_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0] dest_q;
  dist_mode_e           mode_q;
  logic                 level_q;
  logic                 mask_q;
  logic                 prev_q;
  logic [NUM_CORES-1:0] hold_q;
  logic [PTR_W-1:0]     last_q;

  logic                 req, rise;
  logic [NUM_CORES-1:0] rot_sel, low_sel, tgt_d;
  logic [PTR_W-1:0]     rot_idx;

  assign req  = irq_in & ~mask_q & en;
  assign rise = req & ~prev_q;

  rot_pick #(.NUM_CORES(NUM_CORES)) u_pick (
    .cand(dest_q), .last(last_q),
    .pick(rot_sel), .pick_idx(rot_idx), .low_pick(low_sel)
  );

  always_comb begin
    unique case (mode_q)
      DIST_ALL: tgt_d = dest_q;
      DIST_ROT: tgt_d = rise ? rot_sel : hold_q;
      default:  tgt_d = low_sel;
    endcase
    if (level_q) begin
      if (!req) tgt_d = '0;
    end else begin
      if (!rise) tgt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      mode_q  <= DIST_FIXED;
      level_q <= 1'b1;
      mask_q  <= 1'b1;
      prev_q  <= 1'b0;
      hold_q  <= '0;
      last_q  <= PTR_W'(NUM_CORES - 1);
      tgt_o   <= '0;
    end else begin
      prev_q <= req;
      tgt_o  <= tgt_d;
      if (rise && (mode_q == DIST_ROT)) begin
        hold_q <= rot_sel;
        if (|dest_q) last_q <= rot_idx;
      end
      if (wr_dest) dest_q <= wdata[NUM_CORES-1:0];
      if (wr_mode) begin
        mode_q  <= dist_mode_e'(wdata[1:0]);
        level_q <= wdata[TRIG_BIT];
      end
      if (wr_mask) mask_q <= wdata[0];
    end
  end

  // R7
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_q) |-> (tgt_o == '0));
  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (tgt_o == '0));
  // R5
  rot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == DIST_ROT) |-> $onehot0(tgt_o));
  // R9
  dest_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) != DIST_ROT) |-> ((tgt_o & ~$past(dest_q)) == '0));
endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
  import shared_irq_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [2:0]                     cmd_op,
  input  logic [IDX_W-1:0]               cmd_idx,
  input  logic [31:0]                    cmd_data,
  input  logic [NUM_IRQ-1:0]             irq_in,
  output logic [NUM_CORES*NUM_IRQ-1:0]   core_irq,
  output logic [15:0]                    cfg_num_irq
);
  logic en_q;
  logic [NUM_CORES-1:0] lane_tgt [NUM_IRQ];

  assign cfg_num_irq = 16'(NUM_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (cmd_valid && cmd_op == OP_ENABLE) en_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
    logic hit;
    assign hit = cmd_valid && (int'(cmd_idx) == i);

    irq_lane #(.NUM_CORES(NUM_CORES)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en_q), .irq_in(irq_in[i]),
      .wr_dest(hit && cmd_op == OP_DEST),
      .wr_mode(hit && cmd_op == OP_MODE),
      .wr_mask(hit && cmd_op == OP_MASK),
      .wdata(cmd_data), .tgt_o(lane_tgt[i])
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign core_irq[c*NUM_IRQ + i] = lane_tgt[i][c];
    end
  end

  // R8
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> en_q);
endmodule

// File: tb/test_shared_irq_router.sv
module test_shared_irq_router;
  localparam int NI = 8;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [2:0] cmd_idx = 0;
  logic [31:0] cmd_data = 0;
  logic [NI-1:0] irq_in = 0;
  logic [NC*NI-1:0] core_irq;
  logic [15:0] cfg_num_irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  shared_irq_router #(.NUM_IRQ(NI), .NUM_CORES(NC)) i_shared_irq_router (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in),
    .core_irq(core_irq), .cfg_num_irq(cfg_num_irq)
  );

  function automatic logic [NC*NI-1:0] lines(int irq, logic [NC-1:0] cores);
    logic [NC*NI-1:0] v = '0;
    for (int c = 0; c < NC; c++) if (cores[c]) v[c*NI + irq] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [NC*NI-1:0] exp);
    n_run++;
    if (core_irq !== exp) begin
      n_fail++;
      $display("FAIL %s: core_irq=%h expected %h", req, core_irq, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, int idx, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = 3'(idx); cmd_data = d;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic set_in(int irq, logic v);
    @(negedge clk); irq_in[irq] = v; settle();
  endtask

  task automatic t_reset();
    n_run++;
    if (cfg_num_irq !== 16'(NI)) begin
      n_fail++;
      $display("FAIL R11: cfg_num_irq=%0d expected %0d", cfg_num_irq, NI);
    end
    chk("R7 reset quiet", '0);
  endtask

  task automatic t_enable();
    cmd(3'd4, 0, 0); cmd(3'd2, 0, 32'h1);
    set_in(0, 1);
    chk("R8 before enable", '0);
    cmd(3'd5, 0, 32'hFFFF_FFFF);
    settle();
    chk("R1 unknown op no effect", '0);
    cmd(3'd1, 0, 0); settle();
    chk("R8 after enable", lines(0, 4'b0001));
    set_in(0, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); irq_in[0] = 1;
    @(posedge clk); #1;
    chk("R12 input to output one edge", lines(0, 4'b0001));
    @(negedge clk); irq_in[0] = 0;
    #5 chk("R12 not before edge", lines(0, 4'b0001));
    @(posedge clk); #1;
    chk("R12 drop after edge", '0);
    settle();
  endtask

  task automatic t_fixed();
    cmd(3'd4, 2, 0); cmd(3'd2, 2, 32'hC);
    set_in(2, 1);
    chk("R3 fixed lowest core", lines(2, 4'b0100));
    cmd(3'd3, 2, 32'h13); settle();
    chk("R3 mode 3 as fixed", lines(2, 4'b0100));
    cmd(3'd2, 2, 0); settle();
    chk("R9 zero destination", '0);
    set_in(2, 0);
  endtask

  task automatic t_bcast();
    cmd(3'd4, 3, 0); cmd(3'd2, 3, 32'h6); cmd(3'd3, 3, 32'h12);
    set_in(3, 1);
    chk("R4 R2 broadcast", lines(3, 4'b0110));
    cmd(3'd4, 3, 1); settle();
    chk("R7 mask set", '0);
    cmd(3'd4, 3, 0); settle();
    chk("R7 mask clear", lines(3, 4'b0110));
    set_in(3, 0);
  endtask

  task automatic t_rotate();
    logic [NC-1:0] order [4] = '{4'b0001, 4'b0010, 4'b1000, 4'b0001};
    cmd(3'd4, 5, 0); cmd(3'd2, 5, 32'hB);
    cmd(3'd3, 5, 32'hFFFF_FFED); // bits[1:0]=01, bit4=0 -> edge?
    cmd(3'd3, 5, 32'hFFFF_FFFD); // bits[1:0]=01, bit4=1, rest junk -> level rotate
    for (int k = 0; k < 4; k++) begin
      set_in(5, 1);
      chk($sformatf("R5 R10 rotate step %0d", k), lines(5, order[k]));
      set_in(5, 0);
    end
    set_in(5, 1);
    chk("R6 pick", lines(5, 4'b0010));
    cmd(3'd2, 5, 32'h8); settle();
    chk("R6 hold across dest change", lines(5, 4'b0010));
    set_in(5, 0);
  endtask

  task automatic t_edge();
    cmd(3'd4, 6, 0); cmd(3'd2, 6, 32'h2); cmd(3'd3, 6, 32'h0);
    @(negedge clk); irq_in[6] = 1;
    @(posedge clk); #1;
    chk("R10 edge pulse", lines(6, 4'b0010));
    @(posedge clk); #1;
    chk("R10 edge pulse ends", '0);
    settle();
    chk("R10 edge stays low", '0);
    set_in(6, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_latency();
    t_fixed();
    t_bcast();
    t_rotate();
    t_edge();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule